// File: doc/BRIEF.md
# Decode-Stage Hazard and Forwarding Control

This block decides, for the instruction that is being decoded in a five-stage in-order integer pipeline, whether it may advance and where its operands must come from. Conditional branches in this pipeline compare their two registers in the decode stage. The unit therefore guards two consumers. The first is the ALU, which runs one cycle later. The second is the branch comparator, which runs in decode itself.

The inputs are the two source register numbers of the decoding instruction, a flag that marks it as a conditional branch, and the destination, write-enable and load flag of the instructions now in execute and in memory access. From these the unit derives a stall request. The stall request holds the PC and the fetch/decode register and turns the next execute slot into a bubble. The unit also drives a select bit for each branch comparator operand. The two ALU operand selects are decided in decode and registered, so they arrive in step with the instruction when it enters execute. The register file writes before it reads in the same cycle, so a producer three instructions ahead is read directly and needs no forwarding.

Top module: `hazard_ctrl`

## Requirements
- R1: While reset is asserted on a clock edge, both ALU operand selects read 2'b00 (register file) in the cycle that follows, whatever the inputs are.
- R2: A non-branch instruction stalls when it reads a register that the load now in execute will write (load-use). A non-load producer in execute causes no stall for a non-branch instruction.
- R3: A branch stalls when either compare register is written by the non-load instruction now in execute.
- R4: A branch stalls when either compare register is written by the load now in memory access.
- R5: A branch that directly follows a load of one of its compare registers stalls for exactly two consecutive cycles. In the third cycle it proceeds and its compare operand comes from the register file (select 0).
- R6: Register number 0 never causes a stall and never selects a forwarded value, even when a producer names it as its destination with write enabled.
- R7: The ALU select for an operand, seen in the cycle after decode, is 2'b10 when the instruction in execute at decode time writes that register, 2'b01 when only the instruction in memory access writes it, and 2'b00 otherwise.
- R8: When both the execute and memory-access producers write the same source register, the ALU select is 2'b10, because the nearer producer holds the newer value.
- R9: A branch compare select is 1 (take the memory-access result) exactly when the non-load instruction in memory access writes that register. Otherwise it is 0 (register file).
- R10: In the cycle after a stall, both ALU selects are 2'b00, because the execute slot holds a bubble.
- R11: A producer whose write enable is low never causes a stall or a forward, whatever its destination and load flag say.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_src_a | input | 5 | First source register of the decoding instruction |
| dec_src_b | input | 5 | Second source register of the decoding instruction |
| dec_is_branch | input | 1 | Decoding instruction is a conditional branch |
| ex_dst | input | 5 | Destination of the instruction in execute |
| ex_wr | input | 1 | Instruction in execute writes a register |
| ex_ld | input | 1 | Instruction in execute is a load |
| mem_dst | input | 5 | Destination of the instruction in memory access |
| mem_wr | input | 1 | Instruction in memory access writes a register |
| mem_ld | input | 1 | Instruction in memory access is a load |
| stall | output | 1 | Hold PC and fetch/decode register; bubble into execute |
| cmp_sel_a | output | 1 | Branch comparator operand A: 1 = memory-access result, 0 = register file |
| cmp_sel_b | output | 1 | Branch comparator operand B, same coding |
| alu_sel_a | output | 2 | Registered ALU operand A select: 10 memory-stage, 01 writeback-stage, 00 register file |
| alu_sel_b | output | 2 | Registered ALU operand B select, same coding |

## Verification
The bench walks a branch behind a load through three cycles, with the load moving from execute to memory access. A design that stalled only once would let the branch compare a stale value, and one that stalled three times would lose a cycle. Register 0 is named as the destination of both a load and an ALU result. A design that skipped the zero check would stall or forward against a hard-wired zero. Double matches check that the nearer producer wins, and a design with the priority reversed would forward an older value. Producers with write enable low, and the selects that follow a stall, confirm that a bubble never carries a forward into execute.

// File: rtl/hz_pkg.sv
package hz_pkg;

    parameter int REG_W   = 5;
    parameter int NUM_SRC = 2;

    typedef logic [REG_W-1:0] reg_id_t;

    // One in-flight producer as seen from decode
    typedef struct packed {
        reg_id_t dst;
        logic    wr;
        logic    ld;
    } prod_t;

    // ALU operand source, as applied once the instruction reaches execute
    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_WB  = 2'b01,
        FWD_MEM = 2'b10
    } alu_fwd_e;

    function automatic logic writes_src(prod_t p, reg_id_t src);
        return p.wr && (p.dst != '0) && (p.dst == src);
    endfunction

endpackage

// File: rtl/hz_src_check.sv
module hz_src_check
    import hz_pkg::*;
(
    input  reg_id_t  src,
    input  logic     is_branch,
    input  prod_t    ex_p,
    input  prod_t    mem_p,
    output logic     need_stall,
    output logic     cmp_fwd,
    output alu_fwd_e alu_next
);

    logic ex_hit;
    logic mem_hit;

    always_comb begin
        ex_hit  = writes_src(ex_p, src);
        mem_hit = writes_src(mem_p, src);

        // load result one ahead is late for the ALU and the comparator;
        // any result one ahead is late for the comparator;
        // load result two ahead is late for the comparator
        need_stall = (ex_hit && ex_p.ld)
                   || (is_branch && ex_hit)
                   || (is_branch && mem_hit && mem_p.ld);

        cmp_fwd = mem_hit && !mem_p.ld;

        if (ex_hit)
            alu_next = FWD_MEM;
        else if (mem_hit)
            alu_next = FWD_WB;
        else
            alu_next = FWD_RF;
    end

endmodule

// File: rtl/hz_alu_sel_reg.sv
module hz_alu_sel_reg
    import hz_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     stall,
    input  alu_fwd_e sel_d [NUM_SRC],
    output alu_fwd_e sel_q [NUM_SRC]
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_sel
        always_ff @(posedge clk) begin
            if (rst)
                sel_q[i] <= FWD_RF;
            else if (stall)
                sel_q[i] <= FWD_RF;
            else
                sel_q[i] <= sel_d[i];
        end

        AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
            $onehot0(sel_q[i]));                                   // R7
    end

    AST_BUBBLE_NO_FWD: assert property (@(posedge clk) disable iff (rst)
        stall |=> (sel_q[0] == FWD_RF) && (sel_q[1] == FWD_RF));   // R10

endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
    import hz_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] dec_src_a,
    input  logic [REG_W-1:0] dec_src_b,
    input  logic             dec_is_branch,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             ex_wr,
    input  logic             ex_ld,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             mem_wr,
    input  logic             mem_ld,
    output logic             stall,
    output logic             cmp_sel_a,
    output logic             cmp_sel_b,
    output logic [1:0]       alu_sel_a,
    output logic [1:0]       alu_sel_b
);

    prod_t    ex_p;
    prod_t    mem_p;
    reg_id_t  srcs     [NUM_SRC];
    alu_fwd_e alu_next [NUM_SRC];
    alu_fwd_e alu_q    [NUM_SRC];
    logic [NUM_SRC-1:0] need;
    logic [NUM_SRC-1:0] cmp;

    assign ex_p    = '{dst: ex_dst,  wr: ex_wr,  ld: ex_ld};
    assign mem_p   = '{dst: mem_dst, wr: mem_wr, ld: mem_ld};
    assign srcs[0] = dec_src_a;
    assign srcs[1] = dec_src_b;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        hz_src_check u_chk (
            .src        (srcs[i]),
            .is_branch  (dec_is_branch),
            .ex_p       (ex_p),
            .mem_p      (mem_p),
            .need_stall (need[i]),
            .cmp_fwd    (cmp[i]),
            .alu_next   (alu_next[i])
        );
    end

    assign stall = |need;

    hz_alu_sel_reg u_sel (
        .clk   (clk),
        .rst   (rst),
        .stall (stall),
        .sel_d (alu_next),
        .sel_q (alu_q)
    );

    assign cmp_sel_a = cmp[0];
    assign cmp_sel_b = cmp[1];
    assign alu_sel_a = alu_q[0];
    assign alu_sel_b = alu_q[1];

    AST_ZERO_SRC_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        (dec_src_a == '0 && dec_src_b == '0) |-> !stall);          // R6

    AST_BR_ALU_AHEAD_STALL: assert property (@(posedge clk) disable iff (rst)
        (dec_is_branch && ex_wr && !ex_ld && ex_dst != '0
         && (ex_dst == dec_src_a || ex_dst == dec_src_b)) |-> stall); // R3

    AST_CMP_NEVER_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cmp_sel_a || cmp_sel_b) |-> (mem_wr && !mem_ld));        // R9

    AST_NO_WRITER_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        (!ex_wr && !mem_wr) |-> (!stall && !cmp_sel_a && !cmp_sel_b)); // R11

endmodule

// File: tb/sim_hazard_ctrl.sv
module sim_hazard_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] dec_src_a = '0, dec_src_b = '0, ex_dst = '0, mem_dst = '0;
    logic       dec_is_branch = 1'b0, ex_wr = 1'b0, ex_ld = 1'b0;
    logic       mem_wr = 1'b0, mem_ld = 1'b0;
    logic       stall, cmp_sel_a, cmp_sel_b;
    logic [1:0] alu_sel_a, alu_sel_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    hazard_ctrl u0 (
        .clk(clk), .rst(rst),
        .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .dec_is_branch(dec_is_branch),
        .ex_dst(ex_dst), .ex_wr(ex_wr), .ex_ld(ex_ld),
        .mem_dst(mem_dst), .mem_wr(mem_wr), .mem_ld(mem_ld),
        .stall(stall), .cmp_sel_a(cmp_sel_a), .cmp_sel_b(cmp_sel_b),
        .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b)
    );

    typedef struct {
        logic       stall;
        logic       cmp_a;
        logic       cmp_b;
        logic [1:0] nxt_a;
        logic [1:0] nxt_b;
        string      tag;
        string      alu_tag;
    } exp_t;

    exp_t q[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit hit(input logic [4:0] d, input logic w, input logic [4:0] s);
        return w && (d != 5'd0) && (d == s);
    endfunction

    // Driver: apply one decode cycle and push the expected outcome
    task automatic step(input logic [4:0] sa, input logic [4:0] sb, input logic br,
                        input logic [4:0] xd, input logic xw, input logic xl,
                        input logic [4:0] md, input logic mw, input logic ml,
                        input string tag, input string alu_tag);
        exp_t e;
        bit st_a, st_b;
        @(negedge clk);
        dec_src_a = sa; dec_src_b = sb; dec_is_branch = br;
        ex_dst = xd; ex_wr = xw; ex_ld = xl;
        mem_dst = md; mem_wr = mw; mem_ld = ml;
        st_a = (hit(xd, xw, sa) && xl) || (br && hit(xd, xw, sa)) || (br && hit(md, mw, sa) && ml);
        st_b = (hit(xd, xw, sb) && xl) || (br && hit(xd, xw, sb)) || (br && hit(md, mw, sb) && ml);
        e.stall = st_a || st_b;
        e.cmp_a = hit(md, mw, sa) && !ml;
        e.cmp_b = hit(md, mw, sb) && !ml;
        e.nxt_a = e.stall ? 2'b00 : hit(xd, xw, sa) ? 2'b10 : hit(md, mw, sa) ? 2'b01 : 2'b00;
        e.nxt_b = e.stall ? 2'b00 : hit(xd, xw, sb) ? 2'b10 : hit(md, mw, sb) ? 2'b01 : 2'b00;
        e.tag = tag;
        e.alu_tag = alu_tag;
        q.push_back(e);
    endtask

    // Monitor: compare combinational outputs now, registered selects one cycle later
    initial begin
        exp_t cur;
        exp_t prev;
        bit   have_prev = 1'b0;
        forever begin
            @(negedge clk);
            #2;
            if (have_prev) begin
                check(alu_sel_a == prev.nxt_a, prev.alu_tag, "alu_sel_a", alu_sel_a, prev.nxt_a);
                check(alu_sel_b == prev.nxt_b, prev.alu_tag, "alu_sel_b", alu_sel_b, prev.nxt_b);
            end
            if (q.size() > 0) begin
                cur = q.pop_front();
                check(stall == cur.stall, cur.tag, "stall", stall, cur.stall);
                check(cmp_sel_a == cur.cmp_a, cur.tag, "cmp_sel_a", cmp_sel_a, cur.cmp_a);
                check(cmp_sel_b == cur.cmp_b, cur.tag, "cmp_sel_b", cmp_sel_b, cur.cmp_b);
                prev = cur;
                have_prev = 1'b1;
            end else begin
                have_prev = 1'b0;
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset overrides a forwarding match
        dec_src_a = 5'd3; ex_dst = 5'd3; ex_wr = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); #2;
        check(alu_sel_a == 2'b00, "R1", "alu_sel_a", alu_sel_a, 0);
        check(alu_sel_b == 2'b00, "R1", "alu_sel_b", alu_sel_b, 0);
        rst = 1'b0;
        dec_src_a = '0; ex_dst = '0; ex_wr = 1'b0;

        //    sa     sb     br    xd     xw    xl    md     mw    ml
        step(5'd4, 5'd1, 1'b0, 5'd4,  1'b1, 1'b1, 5'd0,  1'b0, 1'b0, "R2", "R10");
        step(5'd4, 5'd1, 1'b0, 5'd4,  1'b1, 1'b0, 5'd0,  1'b0, 1'b0, "R2", "R7");
        step(5'd2, 5'd7, 1'b0, 5'd0,  1'b0, 1'b0, 5'd7,  1'b1, 1'b0, "R7", "R7");
        step(5'd9, 5'd9, 1'b0, 5'd9,  1'b1, 1'b0, 5'd9,  1'b1, 1'b0, "R8", "R8");
        step(5'd1, 5'd6, 1'b1, 5'd6,  1'b1, 1'b0, 5'd0,  1'b0, 1'b0, "R3", "R10");
        step(5'd8, 5'd2, 1'b1, 5'd0,  1'b0, 1'b0, 5'd8,  1'b1, 1'b1, "R4", "R10");
        step(5'd8, 5'd2, 1'b1, 5'd0,  1'b0, 1'b0, 5'd8,  1'b1, 1'b0, "R9", "R7");
        step(5'd3, 5'd11,1'b1, 5'd0,  1'b0, 1'b0, 5'd11, 1'b1, 1'b0, "R9", "R7");
        // R5: load directly ahead of a branch, moving down the pipe
        step(5'd12,5'd1, 1'b1, 5'd12, 1'b1, 1'b1, 5'd0,  1'b0, 1'b0, "R5", "R10");
        step(5'd12,5'd1, 1'b1, 5'd0,  1'b0, 1'b0, 5'd12, 1'b1, 1'b1, "R5", "R10");
        step(5'd12,5'd1, 1'b1, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 1'b0, "R5", "R5");
        // R6: register 0 as destination everywhere
        step(5'd0, 5'd0, 1'b1, 5'd0,  1'b1, 1'b1, 5'd0,  1'b1, 1'b1, "R6", "R6");
        step(5'd0, 5'd0, 1'b0, 5'd0,  1'b1, 1'b0, 5'd0,  1'b1, 1'b0, "R6", "R6");
        // R11: write enable low
        step(5'd5, 5'd13,1'b1, 5'd5,  1'b0, 1'b1, 5'd13, 1'b0, 1'b1, "R11", "R11");
        step(5'd5, 5'd13,1'b0, 5'd5,  1'b0, 1'b0, 5'd13, 1'b0, 1'b0, "R11", "R11");
        step(5'd0, 5'd0, 1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 1'b0, "R7", "R7");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule